// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It divides the system clock down to an AD clock rate and waits for a start request. The request comes either from a software write to its start flag or from a falling edge on an external trigger pin. It then runs a binary search: it drives a trial code to an external DAC and comparator, and it keeps or drops each trial bit from the single comparator bit it reads back. The finished code goes out on a byte-wide write port, using the byte addresses of the channel's result register.

Resolution is 8 or 10 bits, and an optional sample-and-hold phase shortens the conversion. Each channel conversion takes a fixed number of AD cycles set by those two choices. Four operating modes are offered: one-shot on a chosen channel, repeat on a chosen channel, one pass over channels 0 up to a last channel, and repeated passes over that group. The analog input multiplexer follows the channel-select output. The block refuses to start while the reference-connect input is low.

Top module: `sar_seq`

## Requirements
- R1: During and after reset, `busy`, `go_flag`, `done`, `wr_even` and `wr_odd` are 0.
- R2: In software mode (`ext_sel`=0), a write of 1 to the start flag (`go_we`=1, `go_wd`=1) while the flag is 0 and `ref_en`=1 starts a conversion. `busy` and `go_flag` are 1 from that clock edge.
- R3: While `ref_en`=0, a write of 1 to the start flag is ignored: the flag stays 0 and no conversion runs.
- R4: The result write strobe comes T*P clocks after the accepting edge. T is 49 for 8-bit, 59 for 10-bit, 28 for 8-bit with sample-and-hold and 33 for 10-bit with sample-and-hold. P = B*D, where B=1 if `base_full`=1 and B=2 otherwise, and D=1, 2 or 4 for `div_sel`=0, 1 or 2/3.
- R5: The comparator reports 1 when the input is at or above `dac_code`. A 10-bit result equals the 10-bit input. An 8-bit result equals input bits [9:2], because 8-bit trial codes sit in `dac_code[9:2]`.
- R6: `wr_addr` = 2*channel (even). `wr_even` writes `wr_lo` to that byte: result[7:0] for 10-bit, or the 8-bit result. `wr_odd` writes `wr_hi` = result[9:8] to address `wr_addr`+1, and only in 10-bit mode.
- R7: In one-shot mode (`mode`=0), `done` is high for one clock together with the write, and `busy` and `go_flag` clear at the same edge.
- R8: In repeat mode (`mode`=1), conversions of the same channel follow each other every T*P clocks with no `done`, until the flag is cleared.
- R9: A write of 0 to the start flag clears it and abandons any conversion. From the next edge `busy` is 0 and no result is written.
- R10: In external mode (`ext_sel`=1), a write of 1 sets the flag without starting. A conversion starts at the first clock edge where `trig_n` is sampled low after being sampled high, provided the flag and `ref_en` are 1.
- R11: A new falling trigger edge during a conversion restarts it, and the write follows T*P clocks after the latest edge.
- R12: Single sweep (`mode`=2) converts channels 0 to `sweep_last` in order. `done` pulses with the last write, and the flag clears.
- R13: Repeat sweep (`mode`=3) wraps from `sweep_last` back to channel 0 and continues with no `done` until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference connected; required to start |
| go_we | input | 1 | Start-flag write strobe |
| go_wd | input | 1 | Value written to the start flag |
| ext_sel | input | 1 | 1 = external trigger mode |
| trig_n | input | 1 | External trigger, active on falling edge |
| hires | input | 1 | 1 = 10-bit, 0 = 8-bit |
| sh_en | input | 1 | Sample-and-hold enable |
| base_full | input | 1 | 1 = base clock is clk, 0 = clk/2 |
| div_sel | input | 2 | AD clock divider: 0 = /1, 1 = /2, 2 or 3 = /4 |
| mode | input | 2 | 0 one-shot, 1 repeat, 2 single sweep, 3 repeat sweep |
| chan | input | CW | Channel for modes 0 and 1 |
| sweep_last | input | CW | Last channel of a sweep |
| cmp_in | input | 1 | Comparator output |
| go_flag | output | 1 | Start flag |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock completion pulse |
| dac_code | output | 10 | Trial code to the DAC |
| ana_sel | output | CW | Channel being converted |
| wr_even | output | 1 | Write strobe for the even byte |
| wr_odd | output | 1 | Write strobe for the odd byte |
| wr_addr | output | CW+1 | Even byte address of the result |
| wr_lo | output | 8 | Even byte data |
| wr_hi | output | 2 | Odd byte data |

## Verification
The assertions assume that the configuration inputs (resolution, sample-and-hold, divider, mode and channels) are sampled only at the accepting edge. They also assume that `go_we` and `go_wd` are driven to known values from time zero. The stimulus changes configuration only while `busy` is low or at a start, and it drives every input from reset onward. The comparator is modelled as ideal and combinational against a fixed per-channel input, so the binary search always sees a consistent answer within a conversion.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NCH  = 8,
  parameter int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int T8   = 49,
  parameter int T10  = 59,
  parameter int T8S  = 28,
  parameter int T10S = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          go_we,
  input  logic          go_wd,
  input  logic          ext_sel,
  input  logic          trig_n,
  input  logic          hires,
  input  logic          sh_en,
  input  logic          base_full,
  input  logic [1:0]    div_sel,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] chan,
  input  logic [CW-1:0] sweep_last,
  input  logic          cmp_in,
  output logic          go_flag,
  output logic          busy,
  output logic          done,
  output logic [9:0]    dac_code,
  output logic [CW-1:0] ana_sel,
  output logic          wr_even,
  output logic          wr_odd,
  output logic [CW:0]   wr_addr,
  output logic [7:0]    wr_lo,
  output logic [1:0]    wr_hi
);
  localparam int AW = $clog2(T10 + 1);
  localparam logic [9:0] MSB = 10'h200;

  logic          a_hi, a_sh, trig_q;
  logic [1:0]    a_mode;
  logic [CW-1:0] a_last;
  logic [3:0]    plim, plim_in, pcnt;
  logic [AW-1:0] acnt, tot, samp;
  logic [9:0]    sar, mask, dec;
  logic          fall, start, arm, stop, tick, last, ch_end;

  assign tot  = a_hi ? (a_sh ? AW'(T10S) : AW'(T10)) : (a_sh ? AW'(T8S) : AW'(T8));
  assign samp = tot - (a_hi ? AW'(10) : AW'(8));
  assign fall  = trig_q & ~trig_n;
  assign start = ref_en & ((~ext_sel & go_we & go_wd & ~go_flag) | (ext_sel & go_flag & fall));
  assign arm   = ref_en & ext_sel & go_we & go_wd;
  assign stop  = go_we & ~go_wd;
  assign tick  = busy & (pcnt == plim);
  assign last  = tick & (acnt == tot - AW'(1));
  assign dec   = cmp_in ? sar : (sar & ~mask);
  assign ch_end = (ana_sel == a_last);
  assign dac_code = sar;

  always_comb begin
    case (div_sel)
      2'd0:    plim_in = base_full ? 4'd0 : 4'd1;
      2'd1:    plim_in = base_full ? 4'd1 : 4'd3;
      default: plim_in = base_full ? 4'd3 : 4'd7;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_flag <= 1'b0;  busy <= 1'b0;  done <= 1'b0;
      wr_even <= 1'b0;  wr_odd <= 1'b0;
      wr_addr <= '0;    wr_lo <= '0;   wr_hi <= '0;
      a_hi <= 1'b0;     a_sh <= 1'b0;  a_mode <= '0;  a_last <= '0;
      plim <= '0;       pcnt <= '0;    acnt <= '0;
      sar <= '0;        mask <= '0;    ana_sel <= '0;
      trig_q <= 1'b1;
    end else begin
      trig_q  <= trig_n;
      wr_even <= 1'b0;
      wr_odd  <= 1'b0;
      done    <= 1'b0;
      if (busy && !tick) pcnt <= pcnt + 4'd1;
      if (tick) begin
        pcnt <= '0;
        acnt <= acnt + AW'(1);
        if (acnt == samp - AW'(1)) begin
          sar  <= MSB;
          mask <= MSB;
        end else if (acnt >= samp) begin
          sar  <= dec | (mask >> 1);
          mask <= mask >> 1;
        end
        if (last) begin
          wr_even <= 1'b1;
          wr_odd  <= a_hi;
          wr_addr <= {ana_sel, 1'b0};
          wr_lo   <= a_hi ? dec[7:0] : dec[9:2];
          wr_hi   <= a_hi ? dec[9:8] : 2'b00;
          acnt <= '0;
          sar  <= '0;
          mask <= '0;
          case (a_mode)
            2'd0: begin busy <= 1'b0; go_flag <= 1'b0; done <= 1'b1; end
            2'd1: ;
            2'd2:
              if (ch_end) begin busy <= 1'b0; go_flag <= 1'b0; done <= 1'b1; end
              else ana_sel <= ana_sel + CW'(1);
            default: ana_sel <= ch_end ? '0 : ana_sel + CW'(1);
          endcase
        end
      end
      if (arm) go_flag <= 1'b1;
      if (start) begin
        go_flag <= 1'b1;
        busy    <= 1'b1;
        a_hi    <= hires;
        a_sh    <= sh_en;
        a_mode  <= mode;
        a_last  <= sweep_last;
        plim    <= plim_in;
        pcnt    <= '0;
        acnt    <= '0;
        sar     <= '0;
        mask    <= '0;
        ana_sel <= mode[1] ? '0 : chan;
      end
      if (stop) begin
        go_flag <= 1'b0;
        busy    <= 1'b0;
        wr_even <= 1'b0;
        wr_odd  <= 1'b0;
        done    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int AWD = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ref_en,
  input logic           go_we,
  input logic           go_wd,
  input logic           go_flag,
  input logic           busy,
  input logic           done,
  input logic           wr_even,
  input logic           wr_odd,
  input logic [AWD-1:0] wr_addr
);
  AST_ODD_NEEDS_EVEN: assert property (@(posedge clk) disable iff (!rst_n) wr_odd |-> wr_even); // R6
  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n) wr_even |-> !wr_addr[0]); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !go_flag)); // R7
  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done |-> wr_even); // R7
  AST_START_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(ref_en)); // R3
  AST_WRITE_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n) wr_even |-> $past(busy)); // R4
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (go_we && !go_wd) |=> (!busy && !wr_even && !go_flag)); // R9
endmodule

bind sar_seq sar_seq_chk #(.AWD(CW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .go_we(go_we), .go_wd(go_wd),
  .go_flag(go_flag), .busy(busy), .done(done), .wr_even(wr_even),
  .wr_odd(wr_odd), .wr_addr(wr_addr)
);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_en = 1'b1, go_we = 1'b0, go_wd = 1'b0, ext_sel = 1'b0, trig_n = 1'b1;
  logic hires = 1'b0, sh_en = 1'b0, base_full = 1'b1;
  logic [1:0] div_sel = '0, mode = '0;
  logic [2:0] chan = '0, sweep_last = '0;
  logic cmp_in, go_flag, busy, done, wr_even, wr_odd;
  logic [9:0] dac_code;
  logic [2:0] ana_sel;
  logic [3:0] wr_addr;
  logic [7:0] wr_lo;
  logic [1:0] wr_hi;
  logic [9:0] vin [8];

  int cyc = 0, nchk = 0, nfail = 0;

  typedef struct {
    int cyc; logic [3:0] addr; logic [7:0] lo; logic [1:0] hi; logic odd; logic dn;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;
  assign cmp_in = (vin[ana_sel] >= dac_code);

  sar_seq u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .go_we(go_we), .go_wd(go_wd),
    .ext_sel(ext_sel), .trig_n(trig_n), .hires(hires), .sh_en(sh_en),
    .base_full(base_full), .div_sel(div_sel), .mode(mode), .chan(chan),
    .sweep_last(sweep_last), .cmp_in(cmp_in), .go_flag(go_flag), .busy(busy),
    .done(done), .dac_code(dac_code), .ana_sel(ana_sel), .wr_even(wr_even),
    .wr_odd(wr_odd), .wr_addr(wr_addr), .wr_lo(wr_lo), .wr_hi(wr_hi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int tlen(input bit hi, input bit sh);
    return hi ? (sh ? 33 : 59) : (sh ? 28 : 49);
  endfunction

  function automatic int pdiv(input bit bf, input logic [1:0] ds);
    return (bf ? 1 : 2) * ((ds == 2'd0) ? 1 : (ds == 2'd1) ? 2 : 4);
  endfunction

  function automatic void push(input int c, input int ch, input bit hi, input bit dn);
    exp_t e;
    logic [9:0] v;
    v = vin[ch];
    e.cyc = c; e.addr = 4'(ch * 2); e.odd = hi; e.dn = dn;
    e.lo = hi ? v[7:0] : v[9:2];
    e.hi = hi ? v[9:8] : 2'b00;
    sb.push_back(e);
  endfunction

  task automatic go_write(input bit v, output int c);
    @(negedge clk);
    go_we = 1'b1; go_wd = v;
    @(posedge clk);
    #1 c = cyc;
    @(negedge clk);
    go_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_even) begin
      if (sb.size() == 0) chk(0, "R4 unexpected write", wr_addr, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.cyc, "R4 write cycle", cyc, e.cyc);
        chk(wr_addr == e.addr, "R6 even address", wr_addr, e.addr);
        chk(wr_lo == e.lo, "R5 low byte", wr_lo, e.lo);
        chk(wr_odd == e.odd, "R6 odd strobe", wr_odd, e.odd);
        if (e.odd) chk(wr_hi == e.hi, "R5 high bits", wr_hi, e.hi);
        chk(done == e.dn, "R7 done with write", done, e.dn);
      end
    end
    if (rst_n && done && !wr_even) chk(0, "R7 done without write", done, 0);
  end

  initial begin
    #(200000 * 10);
    chk(0, "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int c, c2, t, p;
    vin[0] = 10'h000; vin[1] = 10'h3FF; vin[2] = 10'h155; vin[3] = 10'h2A5;
    vin[4] = 10'h0F3; vin[5] = 10'h1C7; vin[6] = 10'h201; vin[7] = 10'h3FF;
    repeat (3) @(negedge clk);
    chk(!busy && !go_flag && !done && !wr_even && !wr_odd, "R1 state in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !go_flag && !done && !wr_even, "R1 state after reset", go_flag, 0);

    // R2 R4 R5 R6 R7: 10-bit one-shot, P=1
    hires = 1; sh_en = 0; base_full = 1; div_sel = 0; mode = 0; chan = 3;
    go_write(1, c);
    push(c + tlen(1, 0) * pdiv(1, 0), 3, 1, 1);
    chk(busy && go_flag, "R2 busy after software start", busy, 1);
    wait_idle();
    chk(!go_flag && !busy, "R7 flag cleared after one-shot", go_flag, 0);

    // R4 R5: 8-bit, no S/H, P=4 via half base and /2
    hires = 0; sh_en = 0; base_full = 0; div_sel = 1; chan = 1;
    go_write(1, c);
    push(c + tlen(0, 0) * pdiv(0, 1), 1, 0, 1);
    wait_idle();

    // R4 R5: 8-bit with S/H, P=4 via full base and /4
    sh_en = 1; base_full = 1; div_sel = 2; chan = 5;
    go_write(1, c);
    push(c + tlen(0, 1) * pdiv(1, 2), 5, 0, 1);
    wait_idle();

    // R4 R5: 10-bit with S/H, P=8, zero input
    hires = 1; sh_en = 1; base_full = 0; div_sel = 3; chan = 0;
    go_write(1, c);
    push(c + tlen(1, 1) * pdiv(0, 3), 0, 1, 1);
    wait_idle();

    // R5 R6: 10-bit full-scale input
    base_full = 1; div_sel = 0; chan = 7;
    go_write(1, c);
    push(c + tlen(1, 1), 7, 1, 1);
    wait_idle();
    chk(sb.size() == 0, "R4 all single results seen", sb.size(), 0);

    // R3: no reference, start write ignored
    ref_en = 0; chan = 2;
    go_write(1, c);
    repeat (100) @(negedge clk);
    chk(!busy && !go_flag, "R3 start ignored without reference", go_flag, 0);
    ref_en = 1;

    // R10 R11: external trigger with retrigger
    ext_sel = 1; hires = 1; sh_en = 1; chan = 2;
    go_write(1, c);
    repeat (10) @(negedge clk);
    chk(go_flag && !busy, "R10 arm does not start", busy, 0);
    trig_n = 0;
    @(posedge clk);
    #1 chk(busy, "R10 start on falling edge", busy, 1);
    repeat (10) @(negedge clk);
    trig_n = 1;
    @(negedge clk);
    trig_n = 0;
    @(posedge clk);
    #1 c2 = cyc;
    push(c2 + tlen(1, 1), 2, 1, 1);
    wait_idle();
    trig_n = 1;
    ext_sel = 0;
    chk(sb.size() == 0, "R11 single write after retrigger", sb.size(), 0);

    // R8 R9: repeat mode then stop
    mode = 1; hires = 0; sh_en = 1; chan = 4;
    t = tlen(0, 1);
    go_write(1, c);
    for (int k = 1; k <= 3; k++) push(c + k * t, 4, 0, 0);
    repeat (90) @(negedge clk);
    go_write(0, c2);
    chk(!busy && !go_flag, "R9 stop ends repeat", busy, 0);
    repeat (60) @(negedge clk);
    chk(sb.size() == 0, "R8 three repeat results", sb.size(), 0);

    // R9: abandon one-shot
    mode = 0; chan = 6;
    go_write(1, c);
    repeat (15) @(negedge clk);
    go_write(0, c2);
    chk(!busy, "R9 abandon clears busy", busy, 0);
    repeat (60) @(negedge clk);

    // R12: single sweep 0..2, 10-bit, P=2
    mode = 2; sweep_last = 2; hires = 1; sh_en = 0; base_full = 0; div_sel = 0;
    p = pdiv(0, 0); t = tlen(1, 0);
    go_write(1, c);
    for (int k = 0; k < 3; k++) push(c + (k + 1) * t * p, k, 1, k == 2);
    wait_idle();
    chk(!go_flag && sb.size() == 0, "R12 sweep complete and flag cleared", go_flag, 0);

    // R13: repeat sweep 0..1 wraps
    mode = 3; sweep_last = 1; hires = 0; sh_en = 1; base_full = 1; div_sel = 0;
    t = tlen(0, 1);
    go_write(1, c);
    push(c + t, 0, 0, 0); push(c + 2 * t, 1, 0, 0); push(c + 3 * t, 0, 0, 0);
    repeat (90) @(negedge clk);
    go_write(0, c2);
    repeat (40) @(negedge clk);
    chk(sb.size() == 0 && !busy, "R13 wrap order and stop", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule